// File: doc/BRIEF.md
# Inbound Message Interrupt Collector

This block sits beside the inbound path of a serial link and watches every memory write that arrives from the far side. A write counts as an interrupt message when three things hold. Its 64-bit address must equal a programmed target. Its data must carry a programmed signature. Message acceptance must be enabled. Such a write sets one of 32 pending bits, and the low bits of the data pick which one. A single interrupt line summarises all pending bits that are not masked.

Software-side control uses one write port with a register selector. The target address is split across two registers. Bit 0 of the low address register is the enable, and bits 31:1 hold address bits 31:1; address bit 0 of a matching write must be 0. The signature register is split in two halves. Its high half is a compare mask and its low half is the pattern. With the reset value 0xFFE06540, a message for vector n carries data 0x6540 | n. Pending bits are cleared by writing ones. The mask has separate set and clear registers, so no read-modify-write is needed. Pending and mask state are visible on output ports.

Top module: `msi_collector`

## Requirements
- R1: After reset the pending vector is 0, the mask is all ones, irq_o is 0, acceptance is disabled, the target address is 0 and the signature is 0xFFE06540.
- R2: An inbound write is accepted when all of the following hold: acceptance is enabled, in_addr[63:32] equals the high target register, in_addr[31:1] equals bits 31:1 of the low target register, and in_addr[0] is 0. It sets pending bit in_data[4:0] on the next clock edge.
- R3: An inbound write whose address differs in either half from the target leaves the pending vector unchanged.
- R4: An inbound write is ignored if, in any bit position where the signature's high half holds 1, the data differs from the signature's low half. With the default signature, 0x7543 and 0x6560 are both ignored.
- R5: While bit 0 of the low target register is 0, a write that would otherwise match is ignored.
- R6: Writing the clear register (selector 3) clears each pending bit whose data bit is 1. Data bits that are 0 leave the pending vector unchanged.
- R7: Writing selector 4 sets mask bits where the data is 1. Writing selector 5 clears mask bits where the data is 1. Data bits that are 0 change nothing.
- R8: irq_o is 1 exactly when some pending bit is set whose mask bit is 0. A masked vector still records its pending bit.
- R9: When an accepted write and a clear of the same bit fall in the same cycle, the bit ends up set. Other bits named by the clear are still cleared.
- R10: A pending bit stays set across further matching writes to the same vector until it is cleared.
- R11: The signature register (selector 2) is programmable. After it is rewritten, matching uses the new compare mask and pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register selector: 0 target low/enable, 1 target high, 2 signature, 3 clear, 4 mask set, 5 mask clear |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Inbound memory write present this cycle |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 16 | Inbound write data |
| status_o | output | 32 | Pending vector |
| mask_o | output | 32 | Mask vector (1 = masked) |
| irq_o | output | 1 | Summary interrupt |

## Verification
Matching is exercised in several ways. A write that hits every field is followed by writes that miss only the high address, only the low address, only a compared data bit, or only the enable. Each one tells apart a different term of the acceptance condition. Clears are tried alone, together with an accepted write to the same bit, and together with an accepted write to a different bit. These cases separate set-over-clear priority from plain write-one-to-clear. Mask set and clear writes with zero data, and a reprogrammed signature whose mask leaves middle data bits free, show that only the named bits and fields take effect.

// File: rtl/msi_collector.sv
module msi_collector #(
  parameter int NVEC = 32,
  parameter int MSG_W = 16,
  parameter logic [31:0] SIG_RESET = 32'hFFE0_6540
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic             in_valid,
  input  logic [63:0]      in_addr,
  input  logic [MSG_W-1:0] in_data,
  output logic [NVEC-1:0]  status_o,
  output logic [NVEC-1:0]  mask_o,
  output logic             irq_o
);
  localparam int VEC_W = $clog2(NVEC);

  logic [31:0] tgt_lo, tgt_hi, sig;
  logic [NVEC-1:0] status, mask, hit_vec, clr_vec;
  logic addr_ok, data_ok, hit;

  assign addr_ok = (in_addr[63:32] == tgt_hi) && (in_addr[31:1] == tgt_lo[31:1]) && !in_addr[0];
  assign data_ok = ((in_data ^ sig[MSG_W-1:0]) & sig[16 +: MSG_W]) == '0;
  assign hit     = in_valid && tgt_lo[0] && addr_ok && data_ok;
  assign hit_vec = hit ? (NVEC'(1) << in_data[VEC_W-1:0]) : '0;
  assign clr_vec = (cfg_we && cfg_sel == 3'd3) ? cfg_wdata[NVEC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_lo <= '0;
      tgt_hi <= '0;
      sig    <= SIG_RESET;
      status <= '0;
      mask   <= '1;
    end else begin
      status <= (status & ~clr_vec) | hit_vec;
      if (cfg_we) begin
        case (cfg_sel)
          3'd0: tgt_lo <= cfg_wdata;
          3'd1: tgt_hi <= cfg_wdata;
          3'd2: sig    <= cfg_wdata;
          3'd4: mask   <= mask | cfg_wdata[NVEC-1:0];
          3'd5: mask   <= mask & ~cfg_wdata[NVEC-1:0];
          default: ;
        endcase
      end
    end
  end

  assign status_o = status;
  assign mask_o   = mask;
  assign irq_o    = |(status & ~mask);
endmodule

module msi_collector_chk #(
  parameter int NVEC = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [2:0]      cfg_sel,
  input logic [31:0]     cfg_wdata,
  input logic            in_valid,
  input logic [NVEC-1:0] status_o,
  input logic [NVEC-1:0] mask_o,
  input logic            irq_o
);
  // R8
  irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_o != '0 && mask_o != '1));
  // R6
  clear_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 3'd3 && !in_valid) |=> ((status_o & $past(cfg_wdata[NVEC-1:0])) == '0));
  // R3
  quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !(cfg_we && cfg_sel == 3'd3)) |=> $stable(status_o));
  // R7
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 3'd4) |=> ((mask_o & $past(cfg_wdata[NVEC-1:0])) == $past(cfg_wdata[NVEC-1:0])));
  // R7
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 3'd5) |=> ((mask_o & $past(cfg_wdata[NVEC-1:0])) == '0));
  // R2
  one_new_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status_o & ~$past(status_o)) <= 1);
endmodule

bind msi_collector msi_collector_chk #(.NVEC(NVEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .in_valid(in_valid), .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
);

// File: tb/msi_collector_bench.sv
module msi_collector_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic in_valid = 0;
  logic [63:0] in_addr = '0;
  logic [15:0] in_data = '0;
  logic [31:0] status_o, mask_o;
  logic irq_o;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  msi_collector u_msi_collector (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
    .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  localparam logic [63:0] TGT = 64'h0000_0000_FFFF_FFFC;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [2:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic msg(logic [63:0] a, logic [15:0] d);
    @(negedge clk);
    in_valid = 1; in_addr = a; in_data = d;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic msg_and_clear(logic [15:0] d, logic [31:0] c);
    @(negedge clk);
    in_valid = 1; in_addr = TGT; in_data = d;
    cfg_we = 1; cfg_sel = 3'd3; cfg_wdata = c;
    @(negedge clk);
    in_valid = 0; cfg_we = 0;
  endtask

  task automatic t_reset;
    chk("R1 status", status_o, 32'h0);
    chk("R1 mask", mask_o, 32'hFFFF_FFFF);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    msg(64'h0, 16'h6540);
    chk("R1 disabled at reset", status_o, 32'h0);
  endtask

  task automatic t_enable;
    reg_wr(3'd0, 32'hFFFF_FFFC);
    reg_wr(3'd1, 32'h0);
    msg(TGT, 16'h6543);
    chk("R5 enable off", status_o, 32'h0);
    reg_wr(3'd0, 32'hFFFF_FFFD);
    msg(TGT, 16'h6543);
    chk("R2 vector 3", status_o, 32'h8);
    chk("R8 masked no irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_mask;
    reg_wr(3'd5, 32'hFFFF_FFFF);
    chk("R7 mask clear all", mask_o, 32'h0);
    chk("R8 irq on", {31'b0, irq_o}, 32'h1);
    reg_wr(3'd4, 32'h0000_0008);
    chk("R7 mask set one", mask_o, 32'h8);
    chk("R8 irq masked", {31'b0, irq_o}, 32'h0);
    reg_wr(3'd4, 32'h0);
    reg_wr(3'd5, 32'h0);
    chk("R7 zero data", mask_o, 32'h8);
    reg_wr(3'd5, 32'h8);
    chk("R7 unmask", mask_o, 32'h0);
    chk("R8 irq back", {31'b0, irq_o}, 32'h1);
  endtask

  task automatic t_mismatch;
    msg(TGT | 64'h1_0000_0000, 16'h6541);
    chk("R3 high addr", status_o, 32'h8);
    msg(64'hFFFF_FFF8, 16'h6541);
    chk("R3 low addr", status_o, 32'h8);
    msg(TGT | 64'h1, 16'h6541);
    chk("R3 addr bit0", status_o, 32'h8);
    msg(TGT, 16'h7543);
    chk("R4 pattern", status_o, 32'h8);
    msg(TGT, 16'h6560);
    chk("R4 bit5", status_o, 32'h8);
    msg(TGT, 16'h655F);
    chk("R2 vector 31", status_o, 32'h8000_0008);
  endtask

  task automatic t_clear;
    reg_wr(3'd3, 32'h0);
    chk("R6 zero clear", status_o, 32'h8000_0008);
    reg_wr(3'd3, 32'h8);
    chk("R6 clear bit3", status_o, 32'h8000_0000);
  endtask

  task automatic t_race;
    msg_and_clear(16'h655F, 32'h8000_0000);
    chk("R9 set wins", status_o, 32'h8000_0000);
    msg_and_clear(16'h6542, 32'h8000_0000);
    chk("R9 other bit", status_o, 32'h0000_0004);
    msg(TGT, 16'h6542);
    chk("R10 sticky", status_o, 32'h0000_0004);
    reg_wr(3'd3, 32'hFFFF_FFFF);
    chk("R6 clear all", status_o, 32'h0);
    chk("R8 irq idle", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_signature;
    reg_wr(3'd2, 32'hFF00_1200);
    msg(TGT, 16'h1234);
    chk("R11 new sig", status_o, 32'h0010_0000);
    msg(TGT, 16'h1334);
    chk("R11 new mismatch", status_o, 32'h0010_0000);
    msg(TGT, 16'h6541);
    chk("R11 old sig rejected", status_o, 32'h0010_0000);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_enable;
    t_mask;
    t_mismatch;
    t_clear;
    t_race;
    t_signature;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule